// File: doc/BRIEF.md
# Scoreboard Hazard Controller

This block is the central bookkeeping for a machine with four multicycle functional units:
- unit 0, integer;
- unit 1, adder;
- unit 2, multiplier;
- unit 3, divider, which takes one operation at a time.

Decoded instructions arrive in program order on a valid/ready issue port. The block keeps a status record for each unit and a table recording which unit will write each register. From these it decides three things:
- when an issued instruction may take its operands from the register file, signalled by a one-cycle start pulse to its unit;
- when a unit that has finished may write its result back;
- which of several finished units writes first, since only one write-back is granted per cycle.

Results are never forwarded. Every operand comes from the register file. Hazards are therefore resolved in three separate places:
- structural and write-after-write conflicts hold the instruction at issue;
- read-after-write conflicts hold it before the operand read;
- write-after-read conflicts hold its result at write-back.

The issue port follows valid/ready rules. A transfer happens on a rising clock edge where both `iss_valid` and `iss_ready` are high. While `iss_valid` is high the sender keeps every issue field stable. `iss_ready` is a combinational function of `iss_fu` and `iss_dst`, so a stalled instruction blocks every later one. Functional units hold `done_req` high until they see their bit of `wb_grant`.

Top module: `sb_hazard_ctl`

## Requirements
- R1: After reset no unit is busy and no register is pending. `iss_ready` is high, and `fu_start`, `wb_grant` and `wb_valid` are all low.
- R2: `iss_ready` is low while the unit selected by `iss_fu` holds an instruction that has not yet been granted write-back.
- R3: `iss_ready` is low while `iss_dst` is the destination of an instruction in any unit that has not yet been granted write-back.
- R4: An accepted instruction raises its unit's bit of `fu_start` no earlier than the cycle after acceptance, and only once neither source register awaits a write. During the pulse, `fu_op`, `fu_src1` and `fu_src2` carry that unit's opcode and source registers.
- R5: An instruction waiting for a source does not delay a later, independent instruction on another unit; that later instruction may start first.
- R6: `fu_start` pulses for exactly one cycle per accepted instruction.
- R7: A unit requesting write-back to register X is not granted while another busy unit has not yet read X as a source. The grant may come in the cycle after that read at the earliest.
- R8: `wb_grant` is one-hot or zero. `wb_valid` is high exactly when it is non-zero. A grant goes only to a unit that has started and is raising `done_req`. `wb_dst` equals that unit's destination register.
- R9: When several units are eligible in the same cycle, the lowest unit index is granted and the others wait.
- R10: In the cycle after a grant, the granted unit is free for issue, its register is no longer pending, and instructions waiting on that register may start.
- R11: If an instruction is accepted in the same cycle that its source register is granted write-back, that source counts as available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | Issue accepted on this edge if valid |
| iss_fu | input | FU_W | Target unit (0 int, 1 add, 2 mul, 3 div) |
| iss_op | input | OP_W | Opcode passed to the unit |
| iss_dst | input | REG_W | Destination register |
| iss_src1 | input | REG_W | First source register |
| iss_src2 | input | REG_W | Second source register |
| fu_start | output | NUM_FU | Per-unit operand-read and start pulse |
| fu_op | output | NUM_FU x OP_W | Opcode held by each unit |
| fu_src1 | output | NUM_FU x REG_W | First register-file read address per unit |
| fu_src2 | output | NUM_FU x REG_W | Second register-file read address per unit |
| done_req | input | NUM_FU | Unit has a result and asks to write it |
| wb_grant | output | NUM_FU | One-hot write-back grant |
| wb_valid | output | 1 | A write-back happens this cycle |
| wb_dst | output | REG_W | Register written this cycle |

## Verification
The checker enforces the following on every cycle:
- the grant vector is one-hot and only covers requesting units;
- a unit or destination register just issued to cannot be accepted again in the next cycle;
- no start pulse lasts longer than one cycle.

The write-after-read hold, the lowest-index priority, and the release of waiting readers after a write need particular instruction mixes. So do out-of-order starts and same-cycle issue-and-write-back. Only the bench's directed scenarios show those behaviours, with expected cycles worked out from the requirements.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    UNIT_INT = 2'd0,
    UNIT_ADD = 2'd1,
    UNIT_MUL = 2'd2,
    UNIT_DIV = 2'd3
  } unit_e;
endpackage

// File: rtl/sb_result_tbl.sv
// Register-result table: which registers await a write, and from which unit.
module sb_result_tbl #(
  parameter int NUM_REGS = 16,
  parameter int FU_W     = 2,
  parameter int REG_W    = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            set_en,
  input  logic [REG_W-1:0]                set_reg,
  input  logic [FU_W-1:0]                 set_fu,
  input  logic                            clr_en,
  input  logic [REG_W-1:0]                clr_reg,
  output logic [NUM_REGS-1:0]             pend,
  output logic [NUM_REGS-1:0][FU_W-1:0]   owner
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= '0;
      owner <= '0;
    end else begin
      if (clr_en) pend[clr_reg] <= 1'b0;
      if (set_en) begin
        pend[set_reg]  <= 1'b1;
        owner[set_reg] <= set_fu;
      end
    end
  end
endmodule

// File: rtl/sb_wb_select.sv
// Write-back eligibility with write-after-read hold and lowest-index priority.
module sb_wb_select #(
  parameter int NUM_FU = 4,
  parameter int FU_W   = 2,
  parameter int REG_W  = 4
) (
  input  logic [NUM_FU-1:0]             busy,
  input  logic [NUM_FU-1:0]             started,
  input  logic [NUM_FU-1:0]             done_req,
  input  logic [NUM_FU-1:0][REG_W-1:0]  dst,
  input  logic [NUM_FU-1:0][REG_W-1:0]  fj,
  input  logic [NUM_FU-1:0][REG_W-1:0]  fk,
  input  logic [NUM_FU-1:0]             rj,
  input  logic [NUM_FU-1:0]             rk,
  output logic [NUM_FU-1:0]             grant,
  output logic                          wb_valid,
  output logic [FU_W-1:0]               wb_fu,
  output logic [REG_W-1:0]              wb_dst
);
  logic [NUM_FU-1:0] war_hold;
  logic [NUM_FU-1:0] elig;

  for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
    always_comb begin
      war_hold[u] = 1'b0;
      for (int v = 0; v < NUM_FU; v++) begin
        if (v != u && busy[v] &&
            ((rj[v] && fj[v] == dst[u]) || (rk[v] && fk[v] == dst[u])))
          war_hold[u] = 1'b1;
      end
    end
    assign elig[u] = done_req[u] && started[u] && !war_hold[u];
  end

  assign grant    = elig & (~elig + NUM_FU'(1));
  assign wb_valid = |elig;

  always_comb begin
    wb_fu = '0;
    for (int i = NUM_FU - 1; i >= 0; i--)
      if (elig[i]) wb_fu = FU_W'(i);
  end

  assign wb_dst = dst[wb_fu];
endmodule

// File: rtl/sb_hazard_ctl.sv
// Top: issue gate, per-unit status and operand-read release.
module sb_hazard_ctl #(
  parameter int NUM_FU   = 4,
  parameter int NUM_REGS = 16,
  parameter int OP_W     = 4,
  localparam int FU_W    = $clog2(NUM_FU),
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            iss_valid,
  output logic                            iss_ready,
  input  logic [FU_W-1:0]                 iss_fu,
  input  logic [OP_W-1:0]                 iss_op,
  input  logic [REG_W-1:0]                iss_dst,
  input  logic [REG_W-1:0]                iss_src1,
  input  logic [REG_W-1:0]                iss_src2,
  output logic [NUM_FU-1:0]               fu_start,
  output logic [NUM_FU-1:0][OP_W-1:0]     fu_op,
  output logic [NUM_FU-1:0][REG_W-1:0]    fu_src1,
  output logic [NUM_FU-1:0][REG_W-1:0]    fu_src2,
  input  logic [NUM_FU-1:0]               done_req,
  output logic [NUM_FU-1:0]               wb_grant,
  output logic                            wb_valid,
  output logic [REG_W-1:0]                wb_dst
);
  logic [NUM_FU-1:0]             busy, started, rj, rk, qj_vld, qk_vld;
  logic [NUM_FU-1:0][REG_W-1:0]  dst;
  logic [NUM_FU-1:0][FU_W-1:0]   qj, qk;
  logic [NUM_REGS-1:0]           pend;
  logic [NUM_REGS-1:0][FU_W-1:0] owner;
  logic [FU_W-1:0]               wb_fu;
  logic                          fire, s1_free, s2_free;

  assign iss_ready = !busy[iss_fu] && !pend[iss_dst];
  assign fire      = iss_valid && iss_ready;
  // a source written back this very cycle is readable from the next cycle on
  assign s1_free   = !pend[iss_src1] || (wb_valid && wb_dst == iss_src1);
  assign s2_free   = !pend[iss_src2] || (wb_valid && wb_dst == iss_src2);
  assign fu_start  = busy & ~started & rj & rk;

  sb_result_tbl #(.NUM_REGS(NUM_REGS), .FU_W(FU_W), .REG_W(REG_W)) tbl_i (
    .clk(clk), .rst_n(rst_n),
    .set_en(fire), .set_reg(iss_dst), .set_fu(iss_fu),
    .clr_en(wb_valid), .clr_reg(wb_dst),
    .pend(pend), .owner(owner)
  );

  sb_wb_select #(.NUM_FU(NUM_FU), .FU_W(FU_W), .REG_W(REG_W)) sel_i (
    .busy(busy), .started(started), .done_req(done_req), .dst(dst),
    .fj(fu_src1), .fk(fu_src2), .rj(rj), .rk(rk),
    .grant(wb_grant), .wb_valid(wb_valid), .wb_fu(wb_fu), .wb_dst(wb_dst)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= '0; started <= '0; rj <= '0; rk <= '0;
      qj_vld <= '0; qk_vld <= '0; qj <= '0; qk <= '0;
      dst <= '0; fu_op <= '0; fu_src1 <= '0; fu_src2 <= '0;
    end else begin
      for (int u = 0; u < NUM_FU; u++) begin
        if (fire && iss_fu == FU_W'(u)) begin
          busy[u]    <= 1'b1;
          started[u] <= 1'b0;
          fu_op[u]   <= iss_op;
          dst[u]     <= iss_dst;
          fu_src1[u] <= iss_src1;
          fu_src2[u] <= iss_src2;
          rj[u]      <= s1_free;
          rk[u]      <= s2_free;
          qj_vld[u]  <= !s1_free;
          qk_vld[u]  <= !s2_free;
          qj[u]      <= owner[iss_src1];
          qk[u]      <= owner[iss_src2];
        end else if (wb_grant[u]) begin
          busy[u] <= 1'b0; started[u] <= 1'b0;
          rj[u] <= 1'b0; rk[u] <= 1'b0;
          qj_vld[u] <= 1'b0; qk_vld[u] <= 1'b0;
        end else begin
          if (fu_start[u]) begin
            started[u] <= 1'b1;
            rj[u] <= 1'b0;        // operands read: releases held write-backs
            rk[u] <= 1'b0;
          end
          if (wb_valid && qj_vld[u] && qj[u] == wb_fu) begin
            rj[u] <= 1'b1; qj_vld[u] <= 1'b0;
          end
          if (wb_valid && qk_vld[u] && qk[u] == wb_fu) begin
            rk[u] <= 1'b1; qk_vld[u] <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sb_hazard_ctl_chk.sv
module sb_hazard_ctl_chk #(
  parameter int NUM_FU   = 4,
  parameter int NUM_REGS = 16,
  localparam int FU_W    = $clog2(NUM_FU),
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              iss_valid,
  input logic              iss_ready,
  input logic [FU_W-1:0]   iss_fu,
  input logic [REG_W-1:0]  iss_dst,
  input logic [NUM_FU-1:0] fu_start,
  input logic [NUM_FU-1:0] done_req,
  input logic [NUM_FU-1:0] wb_grant,
  input logic              wb_valid
);
  // R8
  a_r8_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wb_grant) && (wb_valid == (wb_grant != '0)));
  // R8
  a_r8_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_grant & ~done_req) == '0);
  // R2
  a_r2_unit_held: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |=> !(iss_valid && iss_ready && iss_fu == $past(iss_fu)));
  // R3
  a_r3_dst_held: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |=> !(iss_valid && iss_ready && iss_dst == $past(iss_dst)));
  // R6
  a_r6_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    (fu_start != '0) |=> ((fu_start & $past(fu_start)) == '0));
endmodule

bind sb_hazard_ctl sb_hazard_ctl_chk #(.NUM_FU(NUM_FU), .NUM_REGS(NUM_REGS)) chk_i (.*);

// File: tb/sb_hazard_ctl_tb_top.sv
`timescale 1ns/1ps
module sb_hazard_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             iss_valid = 0;
  logic             iss_ready;
  logic [1:0]       iss_fu = 0;
  logic [3:0]       iss_op = 0, iss_dst = 0, iss_src1 = 0, iss_src2 = 0;
  logic [3:0]       fu_start, done_req = 0, wb_grant;
  logic [3:0][3:0]  fu_op, fu_src1, fu_src2;
  logic             wb_valid;
  logic [3:0]       wb_dst;

  int n_tests = 0, n_fail = 0;

  sb_hazard_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_fu(iss_fu), .iss_op(iss_op), .iss_dst(iss_dst), .iss_src1(iss_src1),
    .iss_src2(iss_src2), .fu_start(fu_start), .fu_op(fu_op), .fu_src1(fu_src1),
    .fu_src2(fu_src2), .done_req(done_req), .wb_grant(wb_grant),
    .wb_valid(wb_valid), .wb_dst(wb_dst)
  );

  // stimulus vectors {unit, dst, src1, src2}; expected start/grant bit is 1<<unit
  localparam logic [13:0] VEC [6] = '{
    {2'd0, 4'd1,  4'd2,  4'd3},
    {2'd1, 4'd5,  4'd5,  4'd6},
    {2'd2, 4'd15, 4'd0,  4'd0},
    {2'd3, 4'd7,  4'd8,  4'd9},
    {2'd1, 4'd0,  4'd15, 4'd14},
    {2'd3, 4'd3,  4'd3,  4'd3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] f, input logic [3:0] d, input logic [3:0] a,
                       input logic [3:0] b);
    iss_valid = 1; iss_fu = f; iss_dst = d; iss_src1 = a; iss_src2 = b;
  endtask

  task automatic nxt;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) nxt();
    rst_n = 1;
    nxt(); #1;
    chk("R1 ready", iss_ready, 1);
    chk("R1 start", fu_start, 0);
    chk("R1 grant", wb_grant, 0);
    chk("R1 wb_valid", wb_valid, 0);

    // vector walk: single instructions on an idle machine
    for (int i = 0; i < 6; i++) begin
      logic [1:0] f; logic [3:0] d, a, b;
      {f, d, a, b} = VEC[i];
      nxt(); drive(f, d, a, b); iss_op = 4'(i); #1;
      chk("R1 ready idle", iss_ready, 1);
      nxt(); iss_valid = 0; #1;
      chk("R4 start", fu_start, 32'(1) << f);
      chk("R4 op", fu_op[f], i);
      chk("R4 src1", fu_src1[f], a);
      chk("R4 src2", fu_src2[f], b);
      chk("R2 busy unit", iss_ready, 0);
      nxt(); #1;
      chk("R6 single pulse", fu_start, 0);
      done_req[f] = 1; #1;
      chk("R8 grant", wb_grant, 32'(1) << f);
      chk("R8 wb_dst", wb_dst, d);
      chk("R8 wb_valid", wb_valid, 1);
      nxt(); done_req = 0; #1;
      chk("R10 grant gone", wb_grant, 0);
      chk("R10 unit free", iss_ready, 1);
    end

    // RAW wait and out-of-order start
    nxt(); drive(3, 1, 2, 3);
    nxt(); #1; chk("R4 div start", fu_start, 4'b1000);
    drive(1, 4, 1, 5);
    nxt(); #1; chk("R4 add waits on r1", fu_start, 0);
    drive(2, 6, 5, 7);
    nxt(); iss_valid = 0; #1; chk("R5 mul starts first", fu_start, 4'b0100);
    nxt(); done_req = 4'b0100; #1; chk("R8 mul grant", wb_grant, 4'b0100);
    nxt(); done_req = 4'b1000; #1; chk("R8 div grant", wb_grant, 4'b1000);
    chk("R8 div dst", wb_dst, 1);
    nxt(); done_req = 0; #1; chk("R10 add released", fu_start, 4'b0010);
    nxt(); done_req = 4'b0010; #1; chk("R8 add grant", wb_grant, 4'b0010);
    chk("R8 add dst", wb_dst, 4);
    nxt(); done_req = 0;

    // WAW at issue, WAR at write-back
    nxt(); drive(2, 1, 2, 3);
    nxt(); drive(1, 1, 1, 5); #1;
    chk("R3 waw stall", iss_ready, 0);
    chk("R4 mul start", fu_start, 4'b0100);
    iss_dst = 4; #1; chk("R3 other dst ok", iss_ready, 1);
    nxt(); drive(0, 5, 6, 7); #1; chk("R4 add waits", fu_start, 0);
    nxt(); iss_valid = 0; #1; chk("R4 int start", fu_start, 4'b0001);
    nxt(); done_req = 4'b0001; #1; chk("R7 war hold", wb_grant, 0);
    nxt(); #1; chk("R7 war hold 2", wb_grant, 0);
    nxt(); done_req = 4'b0101; #1; chk("R7 mul passes held int", wb_grant, 4'b0100);
    nxt(); done_req = 4'b0001; #1;
    chk("R10 add reads", fu_start, 4'b0010);
    chk("R7 hold during read", wb_grant, 0);
    nxt(); #1; chk("R7 released", wb_grant, 4'b0001);
    chk("R7 dst", wb_dst, 5);
    nxt(); done_req = 4'b0010; #1; chk("R8 add grant", wb_grant, 4'b0010);
    nxt(); done_req = 0;

    // fixed priority
    nxt(); drive(0, 1, 0, 0);
    nxt(); drive(1, 2, 0, 0);
    nxt(); drive(2, 3, 0, 0);
    nxt(); iss_valid = 0;
    nxt(); done_req = 4'b0111; #1; chk("R9 first", wb_grant, 4'b0001);
    chk("R9 first dst", wb_dst, 1);
    nxt(); #1; chk("R9 second", wb_grant, 4'b0010);
    chk("R9 second dst", wb_dst, 2);
    nxt(); #1; chk("R9 third", wb_grant, 4'b0100);
    nxt(); #1; chk("R8 idle request ignored", wb_grant, 0);
    chk("R8 idle wb_valid", wb_valid, 0);
    done_req = 0;

    // source granted in the same cycle as issue
    nxt(); drive(2, 8, 9, 10);
    nxt(); iss_valid = 0; #1; chk("R4 mul start", fu_start, 4'b0100);
    nxt(); done_req = 4'b0100; drive(1, 11, 8, 12); #1;
    chk("R11 grant", wb_grant, 4'b0100);
    chk("R11 ready", iss_ready, 1);
    nxt(); iss_valid = 0; done_req = 0; #1; chk("R11 start", fu_start, 4'b0010);
    nxt(); done_req = 4'b0010; #1; chk("R8 grant", wb_grant, 4'b0010);
    nxt(); done_req = 0;

    nxt();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule